// File: doc/BRIEF.md
# Generic Command Packet FIFO Interface

This block sits between a host processor's 32-bit register bus and a downstream packet serializer in command mode. Software queues the payload of a generic or display-command packet one 32-bit word at a time (bytes packed little-endian, four per word, the last word zero-padded), then writes the four header bytes as a single word. That header write commits the packet. The header, together with the number of payload words queued since the previous commit, goes into a command FIFO that the serializer drains. The serializer then pops exactly that many words from the write payload FIFO.

Read responses coming back from the serializer are pushed into a read payload FIFO. Software pops that FIFO one word at a time through the payload register. One status word packs the empty and full flags of all three FIFOs, a read-in-progress flag and a sticky header-overflow flag. A configuration register supplies two per-packet attributes at commit time: an acknowledge request, and a low-power transmit enable chosen by the packet's data type.

Top module: `gpkt_fifo_if`

## Requirements
- R1: Register offsets: 0x68 is the configuration register (read/write), 0x6C the header register (write), 0x70 the payload register (a write pushes the write FIFO, a read pops the read FIFO), and 0x74 the status register (read). `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value between reads. A read of an unmapped offset returns 0.
- R2: Status word bit layout: bit 0 = command FIFO empty, bit 1 = command FIFO full, bit 2 = write payload FIFO empty, bit 3 = write payload FIFO full, bit 4 = read FIFO empty, bit 5 = read FIFO full, bit 6 = read busy, bit 7 = header overflow. Bits 31:8 read as 0. The flags reflect the state before the edge that samples the read.
- R3: Payload words leave on `tx_pld_word` in the order they were written. One word is removed per cycle while `tx_pld_pop` is high and the FIFO is not empty. A payload write while the write FIFO is full is dropped and is not counted toward the next packet.
- R4: A header write that is accepted presents the header word on `tx_hdr_word`, in FIFO order. `tx_hdr_nwords` carries the count of payload words accepted since the previous accepted header write. That count restarts from zero after each accepted header.
- R5: A header write while the command FIFO is full is dropped and sets status bit 7. Bit 7 stays set until reset. The pending payload word count is kept.
- R6: Once the serializer has taken every header and payload word, status bits 0 and 2 both read 1, which marks the transfer as complete.
- R7: A response word on `rx_word` is stored when `rx_valid` is high and `rx_ready` is high. `rx_ready` is low while the read FIFO is full, and a word offered then is lost. Each read of 0x70 pops one word unchanged, so response byte j stays at bits 8j+7:8j. A read of 0x70 with the read FIFO empty returns 0.
- R8: Read busy (status bit 6) is set by an accepted header whose data type, header bits 5:0, is 0x04, 0x14, 0x24 or 0x06. It is cleared by an accepted response word with `rx_last` high. If both happen on the same edge, set wins.
- R9: `tx_hdr_ack` equals configuration bit 1 as it stood when that header was accepted.
- R10: `tx_hdr_lp` is the configuration bit that the header's data type selects at commit: 0x03→bit 8, 0x13→9, 0x23→10, 0x04→11, 0x14→12, 0x24→13, 0x29→14, 0x05→16, 0x15→17, 0x06→18, 0x39→19, 0x37→24. Any other type gives 0.
- R11: A configuration write keeps only bits 1, 8–14, 16–19 and 24 (mask 0x010F7F02). Reading 0x68 returns the stored value.
- R12: After reset all FIFOs are empty, busy and overflow are clear, `bus_rdata` is 0, and the status word reads 0x15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_hdr_valid | output | 1 | A committed header is available |
| tx_hdr_ready | input | 1 | Serializer takes the head header |
| tx_hdr_word | output | 32 | Header bytes, little-endian |
| tx_hdr_nwords | output | NW | Payload words belonging to this header |
| tx_hdr_ack | output | 1 | Acknowledge requested |
| tx_hdr_lp | output | 1 | Transmit in low-power mode |
| tx_pld_valid | output | 1 | Write payload FIFO not empty |
| tx_pld_pop | input | 1 | Serializer takes the head payload word |
| tx_pld_word | output | 32 | Head payload word |
| rx_valid | input | 1 | Response word offered |
| rx_ready | output | 1 | Read FIFO can take a word |
| rx_word | input | 32 | Response word |
| rx_last | input | 1 | Final word of the response |

## Verification
A read strobe sampled at edge N puts its result on `bus_rdata` right after edge N. That result reflects the FIFO, busy and overflow state from before edge N. A push or pop at edge N shows on the serializer-side outputs and flags right after the same edge, so no result is ever more than one register away from its stimulus. The bench's reference model applies each cycle's inputs at the same edge, using queue sizes taken before any update. All outputs are compared at the falling edge, after the rising edge has settled them and before new stimulus is driven. On top of that comparison, the bench makes directed status and count checks at the cycles worked out above.

// File: rtl/gpkt_pkg.sv
package gpkt_pkg;

  localparam logic [7:0]  OFS_CFG  = 8'h68;
  localparam logic [7:0]  OFS_HDR  = 8'h6C;
  localparam logic [7:0]  OFS_PLD  = 8'h70;
  localparam logic [7:0]  OFS_STAT = 8'h74;

  localparam logic [31:0] CFG_KEEP    = 32'h010F_7F02;
  localparam int unsigned CFG_ACK_BIT = 1;

  // Data types that expect a response
  function automatic logic type_is_read(input logic [5:0] dt);
    return (dt == 6'h04) || (dt == 6'h14) || (dt == 6'h24) || (dt == 6'h06);
  endfunction

  // Low-power enable picked by data type
  function automatic logic type_lp(input logic [5:0] dt, input logic [31:0] cfg);
    logic r;
    case (dt)
      6'h03:   r = cfg[8];
      6'h13:   r = cfg[9];
      6'h23:   r = cfg[10];
      6'h04:   r = cfg[11];
      6'h14:   r = cfg[12];
      6'h24:   r = cfg[13];
      6'h29:   r = cfg[14];
      6'h05:   r = cfg[16];
      6'h15:   r = cfg[17];
      6'h06:   r = cfg[18];
      6'h39:   r = cfg[19];
      6'h37:   r = cfg[24];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] status_word(
    input logic c_empty, input logic c_full,
    input logic w_empty, input logic w_full,
    input logic r_empty, input logic r_full,
    input logic busy,    input logic ovf);
    return {ovf, busy, r_full, r_empty, w_full, w_empty, c_full, c_empty};
  endfunction

endpackage

// File: rtl/gpkt_fifo.sv
module gpkt_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count,
  output logic             push_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/gpkt_regif.sv
module gpkt_regif
  import gpkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [7:0]  status,
  input  logic [31:0] rd_head,
  input  logic        rd_empty,
  output logic        hdr_wr_evt,
  output logic        pld_wr_evt,
  output logic        pld_rd_evt,
  output logic [31:0] cfg_q,
  output logic [31:0] bus_rdata
);

  logic cfg_wr_evt;
  logic [31:0] rd_mux;

  assign hdr_wr_evt = bus_wr && (bus_addr == OFS_HDR);
  assign pld_wr_evt = bus_wr && (bus_addr == OFS_PLD);
  assign cfg_wr_evt = bus_wr && (bus_addr == OFS_CFG);
  assign pld_rd_evt = bus_rd && (bus_addr == OFS_PLD);

  always_comb begin
    case (bus_addr)
      OFS_STAT: rd_mux = {24'd0, status};
      OFS_PLD:  rd_mux = rd_empty ? 32'd0 : rd_head;
      OFS_CFG:  rd_mux = cfg_q;
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (cfg_wr_evt) cfg_q <= bus_wdata & CFG_KEEP;
      if (bus_rd)     bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpkt_commit.sv
module gpkt_commit
  import gpkt_pkg::*;
#(
  parameter int unsigned NW = 4,
  localparam int unsigned ENT_W = 34 + NW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_wr_evt,
  input  logic [31:0]      hdr_word,
  input  logic             hdr_accept,
  input  logic             pld_accept,
  input  logic [31:0]      cfg_q,
  input  logic             rsp_done,
  output logic [ENT_W-1:0] entry,
  output logic             hdr_is_read,
  output logic [NW-1:0]    pend_cnt,
  output logic             rd_busy,
  output logic             hdr_ovf
);

  logic [5:0] dtype;

  assign dtype       = hdr_word[5:0];
  assign hdr_is_read = type_is_read(dtype);
  assign entry       = {type_lp(dtype, cfg_q), cfg_q[CFG_ACK_BIT], pend_cnt, hdr_word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
      rd_busy  <= 1'b0;
      hdr_ovf  <= 1'b0;
    end else begin
      if (hdr_accept)      pend_cnt <= '0;
      else if (pld_accept) pend_cnt <= pend_cnt + 1'b1;

      if (hdr_wr_evt && !hdr_accept) hdr_ovf <= 1'b1;

      if (hdr_accept && hdr_is_read) rd_busy <= 1'b1;
      else if (rsp_done)             rd_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/gpkt_fifo_if.sv
module gpkt_fifo_if
  import gpkt_pkg::*;
#(
  parameter int unsigned CMD_DEPTH  = 4,
  parameter int unsigned WPLD_DEPTH = 8,
  parameter int unsigned RPLD_DEPTH = 4,
  localparam int unsigned NW  = $clog2(WPLD_DEPTH + 1),
  localparam int unsigned CCW = $clog2(CMD_DEPTH + 1),
  localparam int unsigned WCW = $clog2(WPLD_DEPTH + 1),
  localparam int unsigned RCW = $clog2(RPLD_DEPTH + 1),
  localparam int unsigned ENT_W = 34 + NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tx_hdr_valid,
  input  logic          tx_hdr_ready,
  output logic [31:0]   tx_hdr_word,
  output logic [NW-1:0] tx_hdr_nwords,
  output logic          tx_hdr_ack,
  output logic          tx_hdr_lp,
  output logic          tx_pld_valid,
  input  logic          tx_pld_pop,
  output logic [31:0]   tx_pld_word,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [31:0]   rx_word,
  input  logic          rx_last
);

  // Named internal events
  logic             hdr_wr_evt, pld_wr_evt, pld_rd_evt;
  logic             hdr_accept, pld_accept, rsp_accept, rsp_done, hdr_pop;
  logic             cmd_empty, cmd_full, wpld_empty, wpld_full, rd_empty, rd_full;
  logic [CCW-1:0]   cmd_cnt;
  logic [WCW-1:0]   wpld_cnt;
  logic [RCW-1:0]   rd_cnt;
  logic [NW-1:0]    pend_cnt;
  logic             rd_busy, hdr_ovf, hdr_is_read;
  logic [31:0]      cfg_q, rd_head;
  logic [ENT_W-1:0] entry, cmd_head;
  logic [7:0]       status;

  assign status = status_word(cmd_empty, cmd_full, wpld_empty, wpld_full,
                              rd_empty, rd_full, rd_busy, hdr_ovf);

  gpkt_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status     (status),
    .rd_head    (rd_head),
    .rd_empty   (rd_empty),
    .hdr_wr_evt (hdr_wr_evt),
    .pld_wr_evt (pld_wr_evt),
    .pld_rd_evt (pld_rd_evt),
    .cfg_q      (cfg_q),
    .bus_rdata  (bus_rdata)
  );

  gpkt_commit #(.NW(NW)) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_wr_evt  (hdr_wr_evt),
    .hdr_word    (bus_wdata),
    .hdr_accept  (hdr_accept),
    .pld_accept  (pld_accept),
    .cfg_q       (cfg_q),
    .rsp_done    (rsp_done),
    .entry       (entry),
    .hdr_is_read (hdr_is_read),
    .pend_cnt    (pend_cnt),
    .rd_busy     (rd_busy),
    .hdr_ovf     (hdr_ovf)
  );

  gpkt_fifo #(.WIDTH(ENT_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (hdr_wr_evt),
    .push_data (entry),
    .pop       (tx_hdr_ready),
    .head      (cmd_head),
    .empty     (cmd_empty),
    .full      (cmd_full),
    .count     (cmd_cnt),
    .push_ok   (hdr_accept)
  );

  gpkt_fifo #(.WIDTH(32), .DEPTH(WPLD_DEPTH)) u_wpld_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pld_wr_evt),
    .push_data (bus_wdata),
    .pop       (tx_pld_pop),
    .head      (tx_pld_word),
    .empty     (wpld_empty),
    .full      (wpld_full),
    .count     (wpld_cnt),
    .push_ok   (pld_accept)
  );

  gpkt_fifo #(.WIDTH(32), .DEPTH(RPLD_DEPTH)) u_rpld_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_valid),
    .push_data (rx_word),
    .pop       (pld_rd_evt),
    .head      (rd_head),
    .empty     (rd_empty),
    .full      (rd_full),
    .count     (rd_cnt),
    .push_ok   (rsp_accept)
  );

  assign rsp_done      = rsp_accept && rx_last;
  assign rx_ready      = !rd_full;
  assign tx_hdr_valid  = !cmd_empty;
  assign hdr_pop       = tx_hdr_valid && tx_hdr_ready;
  assign tx_pld_valid  = !wpld_empty;
  assign tx_hdr_word   = cmd_head[31:0];
  assign tx_hdr_nwords = cmd_head[32 +: NW];
  assign tx_hdr_ack    = cmd_head[32 + NW];
  assign tx_hdr_lp     = cmd_head[33 + NW];

endmodule

// File: rtl/gpkt_fifo_if_chk.sv
module gpkt_fifo_if_chk #(
  parameter int unsigned NW  = 4,
  parameter int unsigned CCW = 3,
  parameter int unsigned WCW = 4,
  parameter int unsigned RCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hdr_wr_evt,
  input logic           pld_wr_evt,
  input logic           pld_rd_evt,
  input logic           hdr_accept,
  input logic           hdr_pop,
  input logic           hdr_is_read,
  input logic           cmd_empty,
  input logic           cmd_full,
  input logic           wpld_empty,
  input logic           wpld_full,
  input logic           rd_empty,
  input logic           rd_full,
  input logic [CCW-1:0] cmd_cnt,
  input logic [WCW-1:0] wpld_cnt,
  input logic [RCW-1:0] rd_cnt,
  input logic [NW-1:0]  pend_cnt,
  input logic           rd_busy,
  input logic           hdr_ovf,
  input logic           tx_pld_pop,
  input logic           rx_valid
);

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ovf |=> hdr_ovf);

  a_r5_ovf_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr_evt && cmd_full |=> hdr_ovf);

  a_r5_full_hdr_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr_evt && cmd_full && !hdr_pop |=> $stable(cmd_cnt));

  a_r4_pend_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_accept |=> (pend_cnt == '0));

  a_r8_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_accept && hdr_is_read |=> rd_busy);

  a_r3_full_pld_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    pld_wr_evt && wpld_full && !tx_pld_pop |=> $stable(wpld_cnt));

  a_r7_full_rsp_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rd_full && !pld_rd_evt |=> $stable(rd_cnt));

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_empty, cmd_full}) && $onehot0({wpld_empty, wpld_full})
    && $onehot0({rd_empty, rd_full}));

endmodule

bind gpkt_fifo_if gpkt_fifo_if_chk #(.NW(NW), .CCW(CCW), .WCW(WCW), .RCW(RCW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .hdr_wr_evt  (hdr_wr_evt),
  .pld_wr_evt  (pld_wr_evt),
  .pld_rd_evt  (pld_rd_evt),
  .hdr_accept  (hdr_accept),
  .hdr_pop     (hdr_pop),
  .hdr_is_read (hdr_is_read),
  .cmd_empty   (cmd_empty),
  .cmd_full    (cmd_full),
  .wpld_empty  (wpld_empty),
  .wpld_full   (wpld_full),
  .rd_empty    (rd_empty),
  .rd_full     (rd_full),
  .cmd_cnt     (cmd_cnt),
  .wpld_cnt    (wpld_cnt),
  .rd_cnt      (rd_cnt),
  .pend_cnt    (pend_cnt),
  .rd_busy     (rd_busy),
  .hdr_ovf     (hdr_ovf),
  .tx_pld_pop  (tx_pld_pop),
  .rx_valid    (rx_valid)
);

// File: tb/gpkt_fifo_if_tb.sv
`timescale 1ns/1ps
module gpkt_fifo_if_tb_top;

  localparam int CD = 4;
  localparam int WD = 8;
  localparam int RD = 4;
  localparam int NW = $clog2(WD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tx_hdr_valid, tx_hdr_ack, tx_hdr_lp, tx_pld_valid, rx_ready;
  logic tx_hdr_ready = 1'b0, tx_pld_pop = 1'b0;
  logic [31:0] tx_hdr_word, tx_pld_word;
  logic [NW-1:0] tx_hdr_nwords;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [31:0] rx_word = '0;

  always #2 clk = ~clk;

  gpkt_fifo_if #(.CMD_DEPTH(CD), .WPLD_DEPTH(WD), .RPLD_DEPTH(RD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_hdr_valid(tx_hdr_valid),
    .tx_hdr_ready(tx_hdr_ready), .tx_hdr_word(tx_hdr_word), .tx_hdr_nwords(tx_hdr_nwords),
    .tx_hdr_ack(tx_hdr_ack), .tx_hdr_lp(tx_hdr_lp), .tx_pld_valid(tx_pld_valid),
    .tx_pld_pop(tx_pld_pop), .tx_pld_word(tx_pld_word), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_word(rx_word), .rx_last(rx_last));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { logic [31:0] hdr; int nw; bit ack; bit lp; } ent_t;
  ent_t cmdq[$];
  logic [31:0] wq[$], rq[$];
  int pend = 0;
  bit m_busy = 0, m_ovf = 0;
  logic [31:0] m_cfg = 0, exp_rdata = 0;
  logic [7:0] last_rd = 0;

  function automatic bit m_isread(input logic [5:0] t);
    return t inside {6'h04, 6'h14, 6'h24, 6'h06};
  endfunction

  function automatic bit m_lp(input logic [5:0] t, input logic [31:0] c);
    int b;
    case (t)
      6'h03: b = 8;  6'h13: b = 9;  6'h23: b = 10; 6'h04: b = 11;
      6'h14: b = 12; 6'h24: b = 13; 6'h29: b = 14; 6'h05: b = 16;
      6'h15: b = 17; 6'h06: b = 18; 6'h39: b = 19; 6'h37: b = 24;
      default: b = -1;
    endcase
    return (b < 0) ? 1'b0 : c[b];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdq.delete(); wq.delete(); rq.delete();
      pend = 0; m_busy = 0; m_ovf = 0; m_cfg = 0; exp_rdata = 0;
    end else begin
      int csz, wsz, rsz;
      logic [7:0] st;
      bit hacc, rdone;
      ent_t e;
      csz = cmdq.size(); wsz = wq.size(); rsz = rq.size();
      st = {m_ovf, m_busy, rsz == RD, rsz == 0, wsz == WD, wsz == 0, csz == CD, csz == 0};
      hacc = 0; rdone = 0;
      if (bus_rd) begin
        last_rd = bus_addr;
        case (bus_addr)
          8'h74: exp_rdata = {24'd0, st};
          8'h70: exp_rdata = (rsz > 0) ? rq[0] : 32'd0;
          8'h68: exp_rdata = m_cfg;
          default: exp_rdata = 32'd0;
        endcase
        if (bus_addr == 8'h70 && rsz > 0) void'(rq.pop_front());
      end
      if (tx_hdr_ready && csz > 0) void'(cmdq.pop_front());
      if (tx_pld_pop && wsz > 0) void'(wq.pop_front());
      if (rx_valid && rsz < RD) begin
        rq.push_back(rx_word);
        rdone = rx_last;
      end
      if (bus_wr) begin
        case (bus_addr)
          8'h6C: begin
            if (csz < CD) begin
              hacc = 1;
              e.hdr = bus_wdata; e.nw = pend; e.ack = m_cfg[1];
              e.lp = m_lp(bus_wdata[5:0], m_cfg);
              cmdq.push_back(e);
              pend = 0;
            end else m_ovf = 1;
          end
          8'h70: if (wsz < WD) begin wq.push_back(bus_wdata); pend++; end
          8'h68: m_cfg = bus_wdata & 32'h010F_7F02;
          default: ;
        endcase
      end
      if (hacc && m_isread(bus_wdata[5:0])) m_busy = 1;
      else if (rdone) m_busy = 0;
    end
  end

  // Compare every clock at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk((last_rd == 8'h70) ? "R7 rdata" : (last_rd == 8'h68) ? "R11 rdata" : "R1 R2 rdata",
          bus_rdata, exp_rdata);
      chk("R4 hdr valid", tx_hdr_valid, cmdq.size() > 0);
      if (cmdq.size() > 0) begin
        chk("R4 hdr word", tx_hdr_word, cmdq[0].hdr);
        chk("R4 hdr nwords", tx_hdr_nwords, cmdq[0].nw);
        chk("R9 hdr ack", tx_hdr_ack, cmdq[0].ack);
        chk("R10 hdr lp", tx_hdr_lp, cmdq[0].lp);
      end
      chk("R3 pld valid", tx_pld_valid, wq.size() > 0);
      if (wq.size() > 0) chk("R3 pld word", tx_pld_word, wq[0]);
      chk("R7 rx_ready", rx_ready, rq.size() < RD);
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic do_rd(input logic [7:0] a);
    @(negedge clk); #1;
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic rx_send(input logic [31:0] w, input logic l);
    @(negedge clk); #1;
    rx_valid = 1; rx_word = w; rx_last = l;
    @(posedge clk); #1;
    rx_valid = 0; rx_last = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R12 reset state
    chk("R12 rdata reset", bus_rdata, 0);
    do_rd(8'h74); @(negedge clk);
    chk("R12 status reset", bus_rdata, 32'h15);

    // R11 config masking
    do_wr(8'h68, 32'hFFFF_FFFF);
    do_rd(8'h68); @(negedge clk);
    chk("R11 cfg readback", bus_rdata, 32'h010F_7F02);

    // R3 R4 payload then commit
    do_wr(8'h70, 32'h4433_2211);
    do_wr(8'h70, 32'h8877_6655);
    do_wr(8'h70, 32'h0000_00AA);
    do_wr(8'h6C, 32'h0000_0529);
    @(negedge clk);
    chk("R4 nwords 3", tx_hdr_nwords, 3);
    chk("R10 lp long write", tx_hdr_lp, 1);

    // R5 R8 fill command FIFO and overflow
    do_wr(8'h6C, 32'h0000_1103);
    do_wr(8'h6C, 32'h0000_0014);
    do_wr(8'h6C, 32'h0000_0023);
    do_wr(8'h6C, 32'h0000_0005);
    do_rd(8'h74); @(negedge clk);
    chk("R5 R8 status full+ovf+busy", bus_rdata, 32'hD2);

    // R6 drain
    @(negedge clk); #1; tx_hdr_ready = 1; tx_pld_pop = 1;
    repeat (8) @(posedge clk);
    #1; tx_hdr_ready = 0; tx_pld_pop = 0;
    do_rd(8'h74); @(negedge clk);
    chk("R6 complete", bus_rdata[2:0] & 3'b101, 3'b101);
    chk("R5 ovf sticky", bus_rdata[7], 1);

    // R7 R8 responses
    do_wr(8'h68, 32'h0);
    rx_send(32'hDDCC_BBAA, 0);
    rx_send(32'h00EE_FF11, 1);
    do_rd(8'h74); @(negedge clk);
    chk("R8 busy cleared", bus_rdata[6], 0);
    rx_send(32'h1111_1111, 0);
    rx_send(32'h2222_2222, 0);
    rx_send(32'h3333_3333, 0);
    do_rd(8'h74); @(negedge clk);
    chk("R7 status rd full", bus_rdata, 32'hA5);
    do_rd(8'h70); @(negedge clk);
    chk("R7 first word", bus_rdata, 32'hDDCC_BBAA);
    chk("R7 byte0 position", bus_rdata[7:0], 8'hAA);
    for (int i = 0; i < 4; i++) do_rd(8'h70);
    @(negedge clk);
    chk("R7 empty read zero", bus_rdata, 0);

    // R3 payload overfill then commit
    for (int i = 0; i < WD + 2; i++) do_wr(8'h70, 32'hC000_0000 + i);
    do_rd(8'h74); @(negedge clk);
    chk("R3 status wpld full", bus_rdata, 32'h99);
    do_wr(8'h6C, 32'h0000_0039);
    @(negedge clk);
    chk("R3 R4 nwords excludes drops", tx_hdr_nwords, WD);
    chk("R10 lp disabled", tx_hdr_lp, 0);
    chk("R9 ack disabled", tx_hdr_ack, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule